// File: doc/BRIEF.md
# Sixteen-Source Prioritised Interrupt Controller with Vector Code

This controller gathers sixteen interrupt sources and presents them to a processor core. Eight come from external request pins, which are active low. The other eight are internal priority levels, and each level is raised by any internal requester whose one-hot level code selects it. Every external pin passes through a two-flop synchroniser. Software then chooses, pin by pin, whether the pin is captured on a falling edge, where the capture is sticky and cleared by writing 1, or follows the pin's low level. A pending register records all sources. A mask register gates them onto the maskable request line. External pin 0 is non-maskable and drives a request line of its own.

Every cycle a fixed-priority arbiter selects the highest-priority source that is pending and enabled. That selection is registered as an 8-bit vector code and a valid flag. An interrupt handler reads the code and uses it directly as a byte offset into a table of word-sized handler addresses. Software reaches the pending register, the mask register, the pin-mode register and the vector register through a small word-wide register port. Reads come back in the same cycle. Writes take effect at the next clock edge.

Top module: `pic_vec_ctrl`

## Requirements
- R1: After reset the pending, mask and pin-mode registers read zero, irq_req and nmi_req are 0, vec_valid is 0 and vec_code is 0x3C.
- R2: For a pin in level mode (mode bit 0), the pending bit is 1 from the third rising clock edge after the pin goes low, and returns to 0 three edges after the pin goes high.
- R3: For a pin in edge mode (mode bit 1), a falling edge sets the pending bit and the bit stays set after the pin rises. Writing 1 to the bit at address 0 clears it. Writing 0 to it leaves it unchanged.
- R4: Writing 1 to a pending bit that belongs to a level-mode pin or to an internal level has no effect.
- R5: irq_req is 1 exactly when some source other than external pin 0 has both its pending bit and its mask bit at 1.
- R6: nmi_req is 1 while the pending bit of external pin 0 is 1, whatever its mask bit holds. That source never raises irq_req.
- R7: The priority index runs from 0 (highest) to 15 (lowest). External pin k has index 2k and internal level k has index 2k+1.
- R8: One cycle after the pending state changes, vec_code equals 4 times the index of the highest-priority source that is pending and unmasked, and vec_valid is 1. With no such source, vec_code is 0x3C and vec_valid is 0.
- R9: Each internal requester carries an 8-bit one-hot code in which bit 7-k set selects level k (0x80 selects level 0, 0x01 selects level 7). A code of zero requests nothing.
- R10: The register map is as follows. Address 0 is pending, address 1 is mask, address 2 is vector and address 3 is pin mode. Index p sits at bit 31-p of the pending and mask registers. Pin k sits at bit 31-k of the pin-mode register. The vector register reads {code, valid, 23'b0}. Bits 15:0 of the pending and mask registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ext_irq_n | input | 8 | External request pins, active low; bit k is pin k |
| src_req | input | N_INT_SRC | Internal requester strobes, active high |
| src_lvl_code | input | 8*N_INT_SRC | One-hot level codes, 8 bits per requester |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_req | output | 1 | Maskable request to the core |
| nmi_req | output | 1 | Non-maskable request to the core |
| vec_code | output | 8 | Registered vector code |
| vec_valid | output | 1 | Registered flag: vec_code names a live source |

## Verification
A fault in the pending or mask state shows on irq_req and nmi_req in the same cycle. One edge later it also appears on vec_code, because the vector is registered straight from that state. A synchroniser with the wrong number of stages moves the pending bit by whole clock cycles, so the bench samples on both sides of the third edge. If a sticky bit is lost or a write-1-to-clear reaches the wrong bit, the pending register reads the wrong value immediately, and the vector code moves to a different priority slot.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NUM_PIN  = 8;
  localparam int NUM_LVL  = 8;
  localparam int NUM_IDX  = NUM_PIN + NUM_LVL;
  localparam int IDX_W    = $clog2(NUM_IDX);
  localparam int VEC_W    = 8;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 2;

  localparam logic [ADDR_W-1:0] A_PEND = 2'd0;
  localparam logic [ADDR_W-1:0] A_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] A_VEC  = 2'd2;
  localparam logic [ADDR_W-1:0] A_MODE = 2'd3;

  localparam logic [VEC_W-1:0] VEC_IDLE = VEC_W'((NUM_IDX - 1) * 4);

  function automatic logic [VEC_W-1:0] idx_to_code(input logic [IDX_W-1:0] idx);
    return VEC_W'({idx, 2'b00});
  endfunction
endpackage

// File: rtl/pic_ext_detect.sv
module pic_ext_detect #(
  parameter int NUM_PIN     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_PIN-1:0] pin_n,
  input  logic [NUM_PIN-1:0] edge_mode,
  input  logic [NUM_PIN-1:0] clr,
  output logic [NUM_PIN-1:0] pend
);
  for (genvar k = 0; k < NUM_PIN; k++) begin : g_pin
    logic [SYNC_STAGES-1:0] sync_q, sync_d;
    logic                   prev_q;
    logic                   pend_q, pend_d;
    logic                   fall;

    always_comb begin
      sync_d = {sync_q[SYNC_STAGES-2:0], pin_n[k]};
      fall   = prev_q & ~sync_q[SYNC_STAGES-1];
      if (edge_mode[k]) pend_d = fall | (pend_q & ~clr[k]);
      else              pend_d = ~sync_q[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '1;
        prev_q <= 1'b1;
        pend_q <= 1'b0;
      end else begin
        sync_q <= sync_d;
        prev_q <= sync_q[SYNC_STAGES-1];
        pend_q <= pend_d;
      end
    end

    assign pend[k] = pend_q;
  end
endmodule

// File: rtl/pic_lvl_merge.sv
module pic_lvl_merge #(
  parameter int N_SRC   = 4,
  parameter int NUM_LVL = 8
) (
  input  logic [N_SRC-1:0]         src_req,
  input  logic [N_SRC*NUM_LVL-1:0] src_code,
  output logic [NUM_LVL-1:0]       lvl_req
);
  always_comb begin
    lvl_req = '0;
    for (int i = 0; i < N_SRC; i++) begin
      for (int k = 0; k < NUM_LVL; k++) begin
        if (src_req[i] && src_code[i*NUM_LVL + (NUM_LVL-1-k)]) lvl_req[k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
  parameter int NUM_IDX = 16,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_IDX-1:0] req,
  output logic               hit,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int p = NUM_IDX - 1; p >= 0; p--) begin
      if (req[p]) begin
        hit = 1'b1;
        idx = IDX_W'(p);
      end
    end
  end
endmodule

// File: rtl/pic_vec_ctrl.sv
module pic_vec_ctrl
  import pic_pkg::*;
#(
  parameter int N_INT_SRC   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_PIN-1:0]           ext_irq_n,
  input  logic [N_INT_SRC-1:0]         src_req,
  input  logic [N_INT_SRC*NUM_LVL-1:0] src_lvl_code,
  input  logic                         reg_we,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [REG_W-1:0]             reg_wdata,
  output logic [REG_W-1:0]             reg_rdata,
  output logic                         irq_req,
  output logic                         nmi_req,
  output logic [VEC_W-1:0]             vec_code,
  output logic                         vec_valid
);
  logic [1:0]         rst_pipe_q;
  logic               rst_sync_n;
  logic [NUM_PIN-1:0] mode_q, mode_d;
  logic [NUM_IDX-1:0] mask_q, mask_d;
  logic [NUM_LVL-1:0] lvl_q, lvl_req;
  logic [NUM_PIN-1:0] ext_pend, ext_clr;
  logic [NUM_IDX-1:0] pend_all, pend_eff;
  logic               hit;
  logic [IDX_W-1:0]   win_idx;
  logic [VEC_W-1:0]   vec_q, vec_d;
  logic               vld_q, vld_d;
  logic               wr_pend, wr_mask, wr_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign wr_pend = reg_we && (reg_addr == A_PEND);
  assign wr_mask = reg_we && (reg_addr == A_MASK);
  assign wr_mode = reg_we && (reg_addr == A_MODE);

  always_comb begin
    for (int k = 0; k < NUM_PIN; k++) begin
      ext_clr[k] = wr_pend & reg_wdata[REG_W-1-2*k];
      mode_d[k]  = wr_mode ? reg_wdata[REG_W-1-k] : mode_q[k];
    end
    for (int p = 0; p < NUM_IDX; p++) begin
      mask_d[p] = wr_mask ? reg_wdata[REG_W-1-p] : mask_q[p];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr_mode) mode_q <= mode_d;
      if (wr_mask) mask_q <= mask_d;
    end
  end

  pic_ext_detect #(.NUM_PIN(NUM_PIN), .SYNC_STAGES(SYNC_STAGES)) u_ext (
    .clk(clk), .rst_n(rst_sync_n), .pin_n(ext_irq_n),
    .edge_mode(mode_q), .clr(ext_clr), .pend(ext_pend)
  );

  pic_lvl_merge #(.N_SRC(N_INT_SRC), .NUM_LVL(NUM_LVL)) u_lvl (
    .src_req(src_req), .src_code(src_lvl_code), .lvl_req(lvl_req)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) lvl_q <= '0;
    else             lvl_q <= lvl_req;
  end

  for (genvar k = 0; k < NUM_PIN; k++) begin : g_interleave
    assign pend_all[2*k]   = ext_pend[k];
    assign pend_all[2*k+1] = lvl_q[k];
  end

  always_comb begin
    pend_eff    = pend_all & mask_q;
    pend_eff[0] = pend_all[0];
  end

  assign irq_req = |(pend_all[NUM_IDX-1:1] & mask_q[NUM_IDX-1:1]);
  assign nmi_req = pend_all[0];

  pic_prio_enc #(.NUM_IDX(NUM_IDX), .IDX_W(IDX_W)) u_prio (
    .req(pend_eff), .hit(hit), .idx(win_idx)
  );

  always_comb begin
    vld_d = hit;
    vec_d = hit ? idx_to_code(win_idx) : VEC_IDLE;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vec_q <= VEC_IDLE;
      vld_q <= 1'b0;
    end else begin
      vec_q <= vec_d;
      vld_q <= vld_d;
    end
  end

  assign vec_code  = vec_q;
  assign vec_valid = vld_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_PEND: for (int p = 0; p < NUM_IDX; p++) reg_rdata[REG_W-1-p] = pend_all[p];
      A_MASK: for (int p = 0; p < NUM_IDX; p++) reg_rdata[REG_W-1-p] = mask_q[p];
      A_VEC:  reg_rdata[REG_W-1 -: VEC_W+1] = {vec_q, vld_q};
      default: for (int k = 0; k < NUM_PIN; k++) reg_rdata[REG_W-1-k] = mode_q[k];
    endcase
  end
endmodule

// File: rtl/pic_vec_ctrl_chk.sv
module pic_vec_ctrl_chk
  import pic_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               irq_req,
  input logic               vec_valid,
  input logic [VEC_W-1:0]   vec_code,
  input logic [NUM_IDX-1:0] pend,
  input logic [NUM_IDX-1:0] mask,
  input logic [NUM_PIN-1:0] mode,
  input logic               reg_we,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [REG_W-1:0]   reg_wdata
);
  // R8: an empty vector always carries the idle code
  a_r8_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> vec_code == VEC_IDLE);

  // R8: codes are word-aligned offsets
  a_r8_code_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    vec_code[1:0] == 2'b00);

  // R5: no enabled maskable source, no maskable request
  a_r5_masked_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mask[NUM_IDX-1:1] == '0) |-> !irq_req);

  // R6: the non-maskable pin alone never raises the maskable line
  a_r6_nmi_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[NUM_IDX-1:1] == '0) |-> !irq_req);

  // R7: the top-priority source wins the next vector
  a_r7_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pend[0]) |-> (vec_valid && vec_code == 8'h00));

  for (genvar k = 0; k < NUM_PIN; k++) begin : g_hold
    // R3: a latched edge bit stays until written with 1
    a_r3_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode[k]) && mode[k] && $past(pend[2*k]) &&
       !($past(reg_we) && $past(reg_addr) == A_PEND && $past(reg_wdata[REG_W-1-2*k])))
      |-> pend[2*k]);
  end
endmodule

bind pic_vec_ctrl pic_vec_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .irq_req(irq_req), .vec_valid(vec_valid),
  .vec_code(vec_code), .pend(pend_all), .mask(mask_q), .mode(mode_q),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/pic_vec_ctrl_tb.sv
`timescale 1ns/1ps
module pic_vec_ctrl_tb;
  localparam int NS = 4;
  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] ext_irq_n;
  logic [NS-1:0] src_req;
  logic [NS*8-1:0] src_lvl_code;
  logic reg_we;
  logic [1:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic irq_req, nmi_req, vec_valid;
  logic [7:0] vec_code;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pic_vec_ctrl #(.N_INT_SRC(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .src_req(src_req),
    .src_lvl_code(src_lvl_code), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .nmi_req(nmi_req), .vec_code(vec_code), .vec_valid(vec_valid)
  );

  // {mask[15:0] (bit 15 = index 0), pins_n[7:0], src_req[3:0], irq, nmi, valid, code[7:0]}
  // requester codes: src0 0x80 (L0), src1 0x10 (L3), src2 0x01 (L7), src3 0x00
  localparam logic [38:0] TAB [13] = '{
    {16'hFFFF, 8'hFF, 4'b0000, 1'b0, 1'b0, 1'b0, 8'h3C},
    {16'hFFFF, 8'hF7, 4'b0000, 1'b1, 1'b0, 1'b1, 8'h18},
    {16'hFFFF, 8'hFF, 4'b0001, 1'b1, 1'b0, 1'b1, 8'h04},
    {16'hFFFF, 8'hF7, 4'b0001, 1'b1, 1'b0, 1'b1, 8'h04},
    {16'hFFFF, 8'hFE, 4'b0001, 1'b1, 1'b1, 1'b1, 8'h00},
    {16'h0000, 8'hFE, 4'b0000, 1'b0, 1'b1, 1'b1, 8'h00},
    {16'h0000, 8'hF7, 4'b0000, 1'b0, 1'b0, 1'b0, 8'h3C},
    {16'h0200, 8'hF7, 4'b0000, 1'b1, 1'b0, 1'b1, 8'h18},
    {16'h0200, 8'hF7, 4'b0001, 1'b1, 1'b0, 1'b1, 8'h18},
    {16'hFFFF, 8'hFF, 4'b0100, 1'b1, 1'b0, 1'b1, 8'h3C},
    {16'hFFFF, 8'hFF, 4'b1000, 1'b0, 1'b0, 1'b0, 8'h3C},
    {16'hFFFF, 8'h7F, 4'b0010, 1'b1, 1'b0, 1'b1, 8'h1C},
    {16'hFFFF, 8'h00, 4'b1111, 1'b1, 1'b1, 1'b1, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; ext_irq_n = 8'hFF; src_req = '0;
    src_lvl_code = {8'h00, 8'h01, 8'h10, 8'h80};
    reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    wait_edges(4);

    // R1 reset state
    check("R1 irq_req", {31'b0, irq_req}, 32'h0);
    check("R1 nmi_req", {31'b0, nmi_req}, 32'h0);
    check("R1 vec", {23'b0, vec_valid, vec_code}, {23'b0, 1'b0, 8'h3C});
    rd(2'd0, r); check("R1 pending", r, 32'h0);
    rd(2'd1, r); check("R1 mask", r, 32'h0);
    rd(2'd3, r); check("R1 mode", r, 32'h0);
    rd(2'd2, r); check("R10 vector reg layout", r, 32'h3C00_0000);

    // R5 R6 R7 R8 R9 table walk, all pins in level mode
    foreach (TAB[i]) begin
      wr(2'd1, {TAB[i][38:23], 16'h0});
      @(negedge clk);
      ext_irq_n = TAB[i][22:15];
      src_req   = TAB[i][14:11];
      wait_edges(5);
      check($sformatf("R5 irq_req row %0d", i), {31'b0, irq_req}, {31'b0, TAB[i][10]});
      check($sformatf("R6 nmi_req row %0d", i), {31'b0, nmi_req}, {31'b0, TAB[i][9]});
      check($sformatf("R7 R8 R9 vector row %0d", i), {23'b0, vec_valid, vec_code},
            {23'b0, TAB[i][8], TAB[i][7:0]});
    end

    @(negedge clk); ext_irq_n = 8'hFF; src_req = '0;
    wr(2'd1, 32'hFFFF_FFFF);
    wait_edges(5);

    // R10 reserved bits and mode register position
    rd(2'd1, r); check("R10 mask reserved zero", r, 32'hFFFF_0000);
    wr(2'd3, 32'h2000_0000);
    rd(2'd3, r); check("R10 mode pin2 at bit 29", r, 32'h2000_0000);

    // R3 edge capture on pin 2 (index 4, bit 27)
    @(negedge clk) ext_irq_n[2] = 1'b0;
    wait_edges(4);
    @(negedge clk) ext_irq_n[2] = 1'b1;
    wait_edges(4);
    rd(2'd0, r); check("R3 edge sticky", r, 32'h0800_0000);
    check("R3 R8 vector edge", {24'b0, vec_code}, 32'h10);
    wr(2'd0, 32'h0000_0000);
    rd(2'd0, r); check("R3 write 0 keeps", r, 32'h0800_0000);
    wr(2'd0, 32'h0800_0000);
    rd(2'd0, r); check("R3 write 1 clears", r, 32'h0);

    // R2 level latency on pin 5 (index 10, bit 21)
    @(negedge clk) ext_irq_n[5] = 1'b0;
    reg_addr = 2'd0;
    repeat (2) @(posedge clk);
    #1 check("R2 not before third edge", reg_rdata, 32'h0);
    @(posedge clk);
    #1 check("R2 set at third edge", reg_rdata, 32'h0020_0000);

    // R4 write-1 ignored on level and internal bits
    @(negedge clk) src_req = 4'b0001;
    wait_edges(2);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, r); check("R4 clear ignored", r, 32'h4020_0000);

    @(negedge clk) ext_irq_n[5] = 1'b1; src_req = '0;
    wait_edges(3);
    rd(2'd0, r); check("R2 level released", r, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule